// File: doc/BRIEF.md
# Reorder Buffer and Register Rename Table

This block keeps in-flight micro-operations in program order until they commit. Each cycle it accepts a group of up to three micro-operations. Each one is given a buffer slot, and the slot number is its tag. Every operation that writes a register redirects that register's rename entry to the new tag. Execution results arrive later on write-back ports, tagged with a slot number, and may carry an exception flag or a mispredict flag. Results stay inside the buffer entry until retirement. Retirement then copies them into the committed register file.

The buffer is circular. It retires from the oldest end, up to three entries per cycle and strictly in order. An entry can retire only when it has written back and has no flag raised. If the oldest entry written back carries a flag, the block raises a flush. It then discards every in-flight entry and every rename mapping. The committed register file is kept.

Lookup ports serve the rename stage of the next instruction. For a register with no pending writer, a lookup returns the committed value. Otherwise it returns the tag of the youngest pending writer. It also gives a ready bit, and the value when that writer has already finished. Lookups see the state at the start of the cycle, so they do not see allocations made in the same cycle.

Top module: `rob_rat_top`

## Requirements
- R1: While reset is held, no register is mapped. Every lookup then reports ready with value 0, no lane retires, flush is low, and a request group of any size is granted.
- R2: A granted group receives consecutive tags in lane order, starting at the tail slot. Idle lanes are skipped and take no slot. Tags wrap from slot 39 to slot 0.
- R3: A group is granted as a whole only when the number of valid lanes is at most the number of free slots and no flush is raised. Otherwise nothing is allocated and the grant is low.
- R4: From the cycle after a grant, each destination register of the group is mapped to the tag of its lane. When several lanes in a group name the same register, the highest-numbered lane wins.
- R5: A lookup of a mapped register reports its tag. It reports ready only once that entry has written back, and then it returns the written-back value.
- R6: Up to three entries retire per cycle, oldest first. Retiring stops at the first entry that has not written back or that carries a flag. Retire lanes are always a contiguous run starting at lane 0. Each retiring lane shows its destination, its write flag and its data.
- R7: Each retiring entry that writes a register updates the committed value of that register. Within one cycle, a younger lane overrides an older lane.
- R8: At retirement, a register mapping is cleared only if it still names the retiring tag. A mapping already moved to a younger entry is kept.
- R9: When the oldest entry has written back with the exception or mispredict flag, flush is high in that cycle and nothing retires. From the next cycle the buffer is empty, no register is mapped, and the next tag is slot 0.
- R10: A lookup of an unmapped register reports not mapped and ready, and returns the committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 3 | One bit per allocation lane, set when the lane holds a micro-op |
| alloc_has_dst | input | 3 | Lane writes a destination register |
| alloc_dst | input | 9 | 3-bit destination register per lane, lane 0 in the low bits |
| alloc_ok | output | 1 | The whole group is accepted this cycle |
| alloc_tag | output | 18 | 6-bit tag per lane |
| wb_valid | input | 2 | Write-back port active |
| wb_tag | input | 12 | 6-bit tag per write-back port |
| wb_data | input | 64 | 32-bit result per write-back port |
| wb_exc | input | 2 | Result carries an exception |
| wb_mis | input | 2 | Result is a mispredicted branch |
| lk_reg | input | 6 | 3-bit register per lookup port |
| lk_mapped | output | 2 | Register has a pending writer |
| lk_ready | output | 2 | The returned value is valid |
| lk_tag | output | 12 | Tag of the pending writer |
| lk_value | output | 64 | Committed value or written-back value |
| ret_valid | output | 3 | Retiring lanes, oldest entry in lane 0 |
| ret_wr | output | 3 | Retiring lane writes a register |
| ret_dst | output | 9 | 3-bit destination per retire lane |
| ret_data | output | 96 | 32-bit result per retire lane |
| flush | output | 1 | Oldest entry is flagged; all state is discarded at the next edge |

## Verification
The bench fills the buffer with three-lane groups and no write-backs until a group no longer fits. A design that allocated part of that group, or that counted free slots wrongly, would hand out tags that do not match the model. Random traffic sends the tail past slot 39, which catches tag wrap errors. It often repeats a register inside one group and across groups. A design that cleared a mapping without checking the tag would then report a newer writer as unmapped, with a stale committed value. Flags placed on entries behind unfinished ones check two things: that retirement stops before the flagged entry, and that the flush comes only once the entry reaches the oldest position. A flush that was early, or that left mappings in place, shows up on the lookup ports.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Add an offset to a circular slot pointer whose range is 0..depth-1.
  function automatic int wrap_add(int p, int n, int depth);
    int s;
    s = p + n;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // Number of free slots left for a given occupancy.
  function automatic int free_slots(int occ, int depth);
    return depth - occ;
  endfunction

endpackage

// File: rtl/rob_alloc.sv
module rob_alloc
  import rob_pkg::*;
#(
  parameter int DEPTH = 40,
  parameter int LANES = 3,
  parameter int TAG_W = 6,
  parameter int CNT_W = 6
) (
  input  logic [LANES-1:0]       req,
  input  logic [TAG_W-1:0]       tail,
  input  logic [CNT_W-1:0]       occ,
  input  logic                   flush,
  output logic                   grant,
  output logic [LANES-1:0]       fire,
  output logic [LANES*TAG_W-1:0] lane_tag,
  output logic [CNT_W-1:0]       n_alloc
);

  always_comb begin
    int pre;
    pre = 0;
    for (int i = 0; i < LANES; i++) begin
      lane_tag[i*TAG_W +: TAG_W] = TAG_W'(wrap_add(int'(tail), pre, DEPTH));
      if (req[i]) pre = pre + 1;
    end
    grant   = !flush && (pre <= free_slots(int'(occ), DEPTH));
    fire    = grant ? req : '0;
    n_alloc = grant ? CNT_W'(pre) : '0;
  end

endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DEPTH = 40,
  parameter int LANES = 3,
  parameter int TAG_W = 6,
  parameter int CNT_W = 6
) (
  input  logic [TAG_W-1:0]       head,
  input  logic [CNT_W-1:0]       occ,
  input  logic [DEPTH-1:0]       done,
  input  logic [DEPTH-1:0]       exc,
  input  logic [DEPTH-1:0]       mis,
  output logic [LANES-1:0]       go_lane,
  output logic [LANES*TAG_W-1:0] lane_idx,
  output logic [CNT_W-1:0]       n_ret,
  output logic                   flush
);

  always_comb begin
    logic run;
    int   idx;
    int   n;
    run = 1'b1;
    n   = 0;
    for (int k = 0; k < LANES; k++) begin
      idx = wrap_add(int'(head), k, DEPTH);
      lane_idx[k*TAG_W +: TAG_W] = TAG_W'(idx);
      if (run && (k < int'(occ)) && done[idx] && !exc[idx] && !mis[idx]) begin
        go_lane[k] = 1'b1;
        n = n + 1;
      end else begin
        go_lane[k] = 1'b0;
        run = 1'b0;
      end
    end
    n_ret = CNT_W'(n);
    flush = (occ != '0) && done[head] && (exc[head] || mis[head]);
  end

endmodule

// File: rtl/rob_alias.sv
module rob_alias #(
  parameter int NREG   = 8,
  parameter int REG_W  = 3,
  parameter int TAG_W  = 6,
  parameter int ALANES = 3,
  parameter int RLANES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [ALANES-1:0]       a_fire,
  input  logic [ALANES-1:0]       a_wr,
  input  logic [ALANES*REG_W-1:0] a_reg,
  input  logic [ALANES*TAG_W-1:0] a_tag,
  input  logic [RLANES-1:0]       r_fire,
  input  logic [RLANES-1:0]       r_wr,
  input  logic [RLANES*REG_W-1:0] r_reg,
  input  logic [RLANES*TAG_W-1:0] r_tag,
  output logic [NREG-1:0]         map_v,
  output logic [NREG*TAG_W-1:0]   map_t,
  output logic [NREG-1:0]         clr_evt
);

  logic [NREG-1:0]       nxt_v;
  logic [NREG*TAG_W-1:0] nxt_t;

  always_comb begin
    nxt_v   = map_v;
    nxt_t   = map_t;
    clr_evt = '0;
    for (int r = 0; r < NREG; r++) begin
      // retirement clears a mapping only if it still names the retiring slot
      for (int k = 0; k < RLANES; k++) begin
        if (r_fire[k] && r_wr[k] && (r_reg[k*REG_W +: REG_W] == REG_W'(r)) &&
            map_v[r] && (map_t[r*TAG_W +: TAG_W] == r_tag[k*TAG_W +: TAG_W])) begin
          nxt_v[r]   = 1'b0;
          clr_evt[r] = 1'b1;
        end
      end
      // a new writer always takes over; a later lane overrides an earlier one
      for (int i = 0; i < ALANES; i++) begin
        if (a_fire[i] && a_wr[i] && (a_reg[i*REG_W +: REG_W] == REG_W'(r))) begin
          nxt_v[r] = 1'b1;
          nxt_t[r*TAG_W +: TAG_W] = a_tag[i*TAG_W +: TAG_W];
        end
      end
    end
    if (flush) nxt_v = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_v <= '0;
      map_t <= '0;
    end else begin
      map_v <= nxt_v;
      map_t <= nxt_t;
    end
  end

endmodule

// File: rtl/rob_rat_top.sv
module rob_rat_top
  import rob_pkg::*;
#(
  parameter int DEPTH   = 40,
  parameter int ALLOC_W = 3,
  parameter int RET_W   = 3,
  parameter int WB_W    = 2,
  parameter int LK_W    = 2,
  parameter int NREG    = 8,
  parameter int DATA_W  = 32,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int REG_W  = $clog2(NREG),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ALLOC_W-1:0]        alloc_valid,
  input  logic [ALLOC_W-1:0]        alloc_has_dst,
  input  logic [ALLOC_W*REG_W-1:0]  alloc_dst,
  output logic                      alloc_ok,
  output logic [ALLOC_W*TAG_W-1:0]  alloc_tag,
  input  logic [WB_W-1:0]           wb_valid,
  input  logic [WB_W*TAG_W-1:0]     wb_tag,
  input  logic [WB_W*DATA_W-1:0]    wb_data,
  input  logic [WB_W-1:0]           wb_exc,
  input  logic [WB_W-1:0]           wb_mis,
  input  logic [LK_W*REG_W-1:0]     lk_reg,
  output logic [LK_W-1:0]           lk_mapped,
  output logic [LK_W-1:0]           lk_ready,
  output logic [LK_W*TAG_W-1:0]     lk_tag,
  output logic [LK_W*DATA_W-1:0]    lk_value,
  output logic [RET_W-1:0]          ret_valid,
  output logic [RET_W-1:0]          ret_wr,
  output logic [RET_W*REG_W-1:0]    ret_dst,
  output logic [RET_W*DATA_W-1:0]   ret_data,
  output logic                      flush
);

  // entry state
  logic [DEPTH-1:0]  e_valid, e_done, e_exc, e_mis, e_wr;
  logic [REG_W-1:0]  e_dst  [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];
  logic [DATA_W-1:0] rrf    [NREG];
  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  occ;

  // named internal events
  logic [ALLOC_W-1:0]       alloc_fire;
  logic [CNT_W-1:0]         n_alloc;
  logic [RET_W-1:0]         ret_go;
  logic [RET_W*TAG_W-1:0]   ret_idx;
  logic [CNT_W-1:0]         n_ret;
  logic [NREG-1:0]          map_v;
  logic [NREG*TAG_W-1:0]    map_t;
  logic [NREG-1:0]          map_clr;

  rob_alloc #(.DEPTH(DEPTH), .LANES(ALLOC_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_alloc (
    .req(alloc_valid), .tail(tail), .occ(occ), .flush(flush),
    .grant(alloc_ok), .fire(alloc_fire), .lane_tag(alloc_tag), .n_alloc(n_alloc)
  );

  rob_retire #(.DEPTH(DEPTH), .LANES(RET_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_retire (
    .head(head), .occ(occ), .done(e_done), .exc(e_exc), .mis(e_mis),
    .go_lane(ret_go), .lane_idx(ret_idx), .n_ret(n_ret), .flush(flush)
  );

  rob_alias #(.NREG(NREG), .REG_W(REG_W), .TAG_W(TAG_W), .ALANES(ALLOC_W), .RLANES(RET_W)) u_alias (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .a_fire(alloc_fire), .a_wr(alloc_has_dst), .a_reg(alloc_dst), .a_tag(alloc_tag),
    .r_fire(ret_go), .r_wr(ret_wr), .r_reg(ret_dst), .r_tag(ret_idx),
    .map_v(map_v), .map_t(map_t), .clr_evt(map_clr)
  );

  // retire lane outputs
  for (genvar k = 0; k < RET_W; k++) begin : g_ret
    logic [TAG_W-1:0] ix;
    assign ix = ret_idx[k*TAG_W +: TAG_W];
    assign ret_valid[k] = ret_go[k];
    assign ret_wr[k]    = ret_go[k] & e_wr[ix];
    assign ret_dst[k*REG_W +: REG_W]    = e_dst[ix];
    assign ret_data[k*DATA_W +: DATA_W] = e_data[ix];
  end

  // operand lookup
  for (genvar l = 0; l < LK_W; l++) begin : g_lk
    logic [REG_W-1:0] r;
    logic [TAG_W-1:0] tg;
    assign r  = lk_reg[l*REG_W +: REG_W];
    assign tg = map_t[r*TAG_W +: TAG_W];
    assign lk_mapped[l] = map_v[r];
    assign lk_tag[l*TAG_W +: TAG_W] = tg;
    assign lk_ready[l]  = !map_v[r] || e_done[tg];
    assign lk_value[l*DATA_W +: DATA_W] = map_v[r] ? e_data[tg] : rrf[r];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= '0;
      e_done  <= '0;
      e_exc   <= '0;
      e_mis   <= '0;
      e_wr    <= '0;
      head    <= '0;
      tail    <= '0;
      occ     <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_dst[i]  <= '0;
        e_data[i] <= '0;
      end
      for (int r = 0; r < NREG; r++) rrf[r] <= '0;
    end else if (flush) begin
      e_valid <= '0;
      e_done  <= '0;
      e_exc   <= '0;
      e_mis   <= '0;
      head    <= '0;
      tail    <= '0;
      occ     <= '0;
    end else begin
      // commit in lane order so a younger write lands last
      for (int k = 0; k < RET_W; k++) begin
        if (ret_go[k]) begin
          e_valid[ret_idx[k*TAG_W +: TAG_W]] <= 1'b0;
          e_done[ret_idx[k*TAG_W +: TAG_W]]  <= 1'b0;
          if (ret_wr[k]) rrf[ret_dst[k*REG_W +: REG_W]] <= ret_data[k*DATA_W +: DATA_W];
        end
      end
      // write-back only to a live entry still waiting for its result
      for (int w = 0; w < WB_W; w++) begin
        if (wb_valid[w] && e_valid[wb_tag[w*TAG_W +: TAG_W]] && !e_done[wb_tag[w*TAG_W +: TAG_W]]) begin
          e_done[wb_tag[w*TAG_W +: TAG_W]] <= 1'b1;
          e_exc[wb_tag[w*TAG_W +: TAG_W]]  <= wb_exc[w];
          e_mis[wb_tag[w*TAG_W +: TAG_W]]  <= wb_mis[w];
          e_data[wb_tag[w*TAG_W +: TAG_W]] <= wb_data[w*DATA_W +: DATA_W];
        end
      end
      for (int i = 0; i < ALLOC_W; i++) begin
        if (alloc_fire[i]) begin
          e_valid[alloc_tag[i*TAG_W +: TAG_W]] <= 1'b1;
          e_done[alloc_tag[i*TAG_W +: TAG_W]]  <= 1'b0;
          e_exc[alloc_tag[i*TAG_W +: TAG_W]]   <= 1'b0;
          e_mis[alloc_tag[i*TAG_W +: TAG_W]]   <= 1'b0;
          e_wr[alloc_tag[i*TAG_W +: TAG_W]]    <= alloc_has_dst[i];
          e_dst[alloc_tag[i*TAG_W +: TAG_W]]   <= alloc_dst[i*REG_W +: REG_W];
        end
      end
      head <= TAG_W'(wrap_add(int'(head), int'(n_ret), DEPTH));
      tail <= TAG_W'(wrap_add(int'(tail), int'(n_alloc), DEPTH));
      occ  <= occ + n_alloc - n_ret;
    end
  end

endmodule

// File: rtl/rob_rat_chk.sv
module rob_rat_chk #(
  parameter int DEPTH = 40,
  parameter int RET_W = 3,
  parameter int LK_W  = 2,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             alloc_ok,
  input logic [RET_W-1:0] ret_valid,
  input logic [LK_W-1:0]  lk_mapped,
  input logic [CNT_W-1:0] occ
);

  logic [RET_W-1:0] rv_inc;
  assign rv_inc = ret_valid + 1'b1;

  // R6
  ret_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid & rv_inc) == '0);

  // R9
  flush_noret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (ret_valid == '0));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((lk_mapped == '0) && (occ == '0)));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ok && !flush) |=> (occ <= $past(occ)));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

endmodule

bind rob_rat_top rob_rat_chk #(.DEPTH(DEPTH), .RET_W(RET_W), .LK_W(LK_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_ok(alloc_ok),
  .ret_valid(ret_valid), .lk_mapped(lk_mapped), .occ(occ)
);

// File: tb/sim_rob_rat_top.sv
module sim_rob_rat_top;
  localparam int DEPTH = 40, AW = 3, RW = 3, WW = 2, LW = 2, NREG = 8, DW = 32, TW = 6, GW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0]    alloc_valid = '0, alloc_has_dst = '0;
  logic [AW*GW-1:0] alloc_dst = '0;
  logic             alloc_ok;
  logic [AW*TW-1:0] alloc_tag;
  logic [WW-1:0]    wb_valid = '0, wb_exc = '0, wb_mis = '0;
  logic [WW*TW-1:0] wb_tag = '0;
  logic [WW*DW-1:0] wb_data = '0;
  logic [LW*GW-1:0] lk_reg = '0;
  logic [LW-1:0]    lk_mapped, lk_ready;
  logic [LW*TW-1:0] lk_tag;
  logic [LW*DW-1:0] lk_value;
  logic [RW-1:0]    ret_valid, ret_wr;
  logic [RW*GW-1:0] ret_dst;
  logic [RW*DW-1:0] ret_data;
  logic             flush;

  rob_rat_top u0 (.*);

  typedef struct {
    int tag; int dst; bit wr; bit done; bit exc; bit mis; logic [31:0] data;
  } ent_t;

  ent_t        q[$];
  bit          mv[NREG];
  int          mt[NREG];
  logic [31:0] rrf[NREG];
  int          next_tag = 0;
  int          total = 0, bad = 0;
  int          p_alloc = 50, p_wb = 60, p_flag = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int find(int tag);
    for (int i = 0; i < q.size(); i++) if (q[i].tag == tag) return i;
    return -1;
  endfunction

  task automatic step();
    int  pend[$];
    int  n, req, pre, j, first;
    bit  fl, ok;
    // drive inputs
    for (int i = 0; i < AW; i++) begin
      alloc_valid[i]   = ($urandom_range(99) < p_alloc);
      alloc_has_dst[i] = ($urandom_range(99) < 80);
      alloc_dst[i*GW +: GW] = GW'($urandom_range(NREG-1));
    end
    for (int i = 0; i < q.size(); i++) if (!q[i].done) pend.push_back(i);
    wb_valid = '0; wb_exc = '0; wb_mis = '0;
    first = -1;
    for (int w = 0; w < WW; w++) begin
      if (pend.size() > 0 && $urandom_range(99) < p_wb) begin
        j = pend[$urandom_range(pend.size()-1)];
        if (j != first) begin
          first = j;
          wb_valid[w] = 1'b1;
          wb_tag[w*TW +: TW] = TW'(q[j].tag);
          wb_data[w*DW +: DW] = $urandom;
          wb_exc[w] = ($urandom_range(99) < p_flag);
          wb_mis[w] = ($urandom_range(99) < p_flag);
        end
      end
    end
    for (int l = 0; l < LW; l++) lk_reg[l*GW +: GW] = GW'($urandom_range(NREG-1));
    #1;
    // expected outputs
    fl = (q.size() > 0) && q[0].done && (q[0].exc || q[0].mis);
    chk("R9 flush", 32'(flush), 32'(fl));
    n = 0;
    while (n < RW && n < q.size() && q[n].done && !q[n].exc && !q[n].mis) n++;
    chk("R6 retire lanes", 32'(ret_valid), 32'((1 << n) - 1));
    for (int k = 0; k < n; k++) begin
      chk("R7 retire wr", 32'(ret_wr[k]), 32'(q[k].wr));
      if (q[k].wr) begin
        chk("R6 retire dst", 32'(ret_dst[k*GW +: GW]), 32'(q[k].dst));
        chk("R7 retire data", ret_data[k*DW +: DW], q[k].data);
      end
    end
    req = 0;
    for (int i = 0; i < AW; i++) if (alloc_valid[i]) req++;
    ok = !fl && (req <= DEPTH - q.size());
    chk("R3 alloc grant", 32'(alloc_ok), 32'(ok));
    if (ok) begin
      pre = 0;
      for (int i = 0; i < AW; i++) if (alloc_valid[i]) begin
        chk("R2 alloc tag", 32'(alloc_tag[i*TW +: TW]), 32'((next_tag + pre) % DEPTH));
        pre++;
      end
    end
    for (int l = 0; l < LW; l++) begin
      int r;
      r = int'(lk_reg[l*GW +: GW]);
      if (mv[r]) begin
        chk("R4 lookup mapped", 32'(lk_mapped[l]), 32'd1);
        chk("R4/R8 lookup tag", 32'(lk_tag[l*TW +: TW]), 32'(mt[r]));
        j = find(mt[r]);
        if (j < 0) chk("R8 model entry present", 32'd0, 32'd1);
        else begin
          chk("R5 lookup ready", 32'(lk_ready[l]), 32'(q[j].done));
          if (q[j].done) chk("R5 lookup value", lk_value[l*DW +: DW], q[j].data);
        end
      end else begin
        chk("R10 lookup unmapped", 32'(lk_mapped[l]), 32'd0);
        chk("R10 lookup ready", 32'(lk_ready[l]), 32'd1);
        chk("R10 lookup value", lk_value[l*DW +: DW], rrf[r]);
      end
    end
    // advance the model to the state after the coming edge
    if (fl) begin
      q.delete();
      for (int r = 0; r < NREG; r++) mv[r] = 1'b0;
      next_tag = 0;
    end else begin
      for (int k = 0; k < n; k++) begin
        ent_t e;
        e = q.pop_front();
        if (e.wr) begin
          rrf[e.dst] = e.data;
          if (mv[e.dst] && mt[e.dst] == e.tag) mv[e.dst] = 1'b0;
        end
      end
      for (int w = 0; w < WW; w++) if (wb_valid[w]) begin
        j = find(int'(wb_tag[w*TW +: TW]));
        if (j >= 0) begin
          q[j].done = 1'b1;
          q[j].exc  = wb_exc[w];
          q[j].mis  = wb_mis[w];
          q[j].data = wb_data[w*DW +: DW];
        end
      end
      if (ok) for (int i = 0; i < AW; i++) if (alloc_valid[i]) begin
        ent_t e;
        e.tag = next_tag; e.dst = int'(alloc_dst[i*GW +: GW]); e.wr = alloc_has_dst[i];
        e.done = 1'b0; e.exc = 1'b0; e.mis = 1'b0; e.data = '0;
        q.push_back(e);
        if (e.wr) begin mv[e.dst] = 1'b1; mt[e.dst] = e.tag; end
        next_tag = (next_tag + 1) % DEPTH;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) begin mv[r] = 1'b0; mt[r] = 0; rrf[r] = '0; end
    alloc_valid = 3'b111;
    lk_reg = {3'd5, 3'd2};
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 grant", 32'(alloc_ok), 32'd1);
    chk("R1 unmapped", 32'(lk_mapped), 32'd0);
    chk("R1 ready", 32'(lk_ready), 32'd3);
    chk("R1 value", lk_value[31:0], 32'd0);
    chk("R1 retire idle", 32'(ret_valid), 32'd0);
    chk("R1 flush low", 32'(flush), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // fill without write-backs until a group no longer fits (R3)
    p_alloc = 100; p_wb = 0; p_flag = 0;
    repeat (20) step();
    // drain with full write-back traffic (R6, R7)
    p_alloc = 30; p_wb = 100;
    repeat (100) step();
    // mixed traffic, wrap and renaming of shared registers (R2, R4, R8)
    p_alloc = 60; p_wb = 50;
    repeat (1500) step();
    // flagged results and flushes (R9)
    p_flag = 3;
    repeat (1500) step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule